// File: doc/BRIEF.md
# Timer Compare Output Pin Unit

This block is the output stage of one 8-bit timer compare channel. It holds a single output-compare flip-flop and decides, cycle by cycle, what that flip-flop does in response to event pulses from a counter that lives outside the block. The events are a compare match, the counter passing BOTTOM, and the current count direction. A two-bit waveform selector picks the behaviour: normal, clear-on-match (CTC), fast PWM or phase-correct PWM. A two-bit compare-output code picks the action. In the two non-PWM modes the action is set, clear or toggle. In the PWM modes the code picks inverted or non-inverted output. A force strobe can apply the non-PWM action at once, with no match.

The block also drives the port pin. When the compare-output code is nonzero, the flip-flop replaces the general-purpose port data bit on the pin. The pin output enable always follows the data-direction bit. Software can therefore preset the flip-flop with the force strobe while the pin is still an input, and the pin then comes up at a known level when the direction bit is set.

A code written between matches is stored separately from the code in use. Events that come before the next match, such as the BOTTOM action in fast PWM, keep using the code that the last match or force latched. The new code takes over on the next match.

Top module: `tcmp_pin_unit`

## Requirements
- R1: The pin data output equals the flip-flop whenever `com_i` is nonzero, and equals `port_data_i` when `com_i` is 00. The waveform mode has no effect on this selection.
- R2: `pin_oe_o` equals `port_dir_i` in every mode, whatever the value of `com_i`.
- R3: Reset (synchronous, active low) clears the flip-flop to 0 and clears the latched code to 00.
- R4: A compare match with `com_i` = 00 leaves the flip-flop unchanged in all four waveform modes (`wave_mode_i` 00 normal, 01 CTC, 10 fast PWM, 11 phase-correct).
- R5: In normal and CTC modes, a match with `com_i` 01 toggles the flip-flop, 10 clears it and 11 sets it. The new value appears on the clock edge that samples the match.
- R6: In normal and CTC modes, `force_i` applies the action selected by `com_i` on the next clock edge, with no match present.
- R7: In both PWM modes, `force_i` alone leaves the flip-flop unchanged.
- R8: In fast PWM with code 10, a match clears the flip-flop and BOTTOM sets it. Code 11 does the opposite. When a match and BOTTOM arrive in the same cycle, the match action wins.
- R9: In phase-correct PWM with code 10, a match while `count_up_i` = 1 clears the flip-flop and a match while counting down sets it. Code 11 does the opposite. BOTTOM has no effect in this mode.
- R10: In both PWM modes, code 01 leaves the flip-flop idle on matches and on BOTTOM.
- R11: A code written to `com_i` is latched as the code in use at the next match (or at a force in non-PWM modes), and that match already uses it. A BOTTOM event before that match acts with the previously latched code.
- R12: The flip-flop can be preset with a force while `port_dir_i` = 0. When the direction bit is then set, the pin enables with the preset level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wave_mode_i | input | 2 | Waveform mode: 00 normal, 01 CTC, 10 fast PWM, 11 phase-correct PWM |
| com_i | input | 2 | Compare-output code |
| match_i | input | 1 | Compare match pulse from the counter |
| bottom_i | input | 1 | Counter-at-BOTTOM pulse |
| count_up_i | input | 1 | Count direction, 1 = counting up |
| force_i | input | 1 | Force-compare strobe |
| port_data_i | input | 1 | General-purpose port data bit |
| port_dir_i | input | 1 | Data-direction bit, 1 = output |
| pin_out_o | output | 1 | Pin drive value |
| pin_oe_o | output | 1 | Pin output enable |

## Verification
The hardest case to reach is a fast-PWM BOTTOM event that arrives after a new code has been written but before the next match. Only in that window does the latched code differ from the code on the inputs, and only then does the deferred update show at the pin. The stimulus reaches it on purpose: a match latches code 10, the code is switched to 11 without a match, and BOTTOM is then pulsed. The random phase also changes the code only now and then, while BOTTOM pulses are frequent, so the window recurs many times under varied history.

// File: rtl/tcmp_pkg.sv
// Package: shared types for the timer compare output pin unit.
// Assumes two-bit waveform and compare-output codes.
package tcmp_pkg;
    localparam int CODE_W = 2;

    typedef enum logic [1:0] {
        WM_NORMAL = 2'b00,
        WM_CTC    = 2'b01,
        WM_FAST   = 2'b10,
        WM_PHASE  = 2'b11
    } wave_e;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } act_e;

    // True for the two PWM waveform modes
    function automatic logic is_pwm(input wave_e m);
        return (m == WM_FAST) || (m == WM_PHASE);
    endfunction
endpackage

// File: rtl/tcmp_code_latch.sv
// Module: holds the compare-output code that is in use.
// Loads the code on the inputs whenever a qualifying update strobe arrives
// (a match, or a force in non-PWM modes). Assumes the strobe is one cycle wide.
module tcmp_code_latch #(
    parameter int W = tcmp_pkg::CODE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] code_i,
    output logic [W-1:0] code_q
);
    // Latch the new code on each qualifying event; reset to idle code
    always_ff @(posedge clk) begin
        if (!rst_n)      code_q <= '0;
        else if (load_i) code_q <= code_i;
    end
endmodule

// File: rtl/tcmp_action_sel.sv
// Module: combinational choice of the flip-flop action for this cycle.
// Match events use the code on the inputs. BOTTOM events use the latched
// code. In fast PWM a match takes priority over BOTTOM in the same cycle.
// Assumes events are single-cycle pulses.
module tcmp_action_sel
    import tcmp_pkg::*;
(
    input  wave_e             wave_i,
    input  logic [CODE_W-1:0] com_new_i,
    input  logic [CODE_W-1:0] com_act_i,
    input  logic              match_i,
    input  logic              bottom_i,
    input  logic              up_i,
    input  logic              force_i,
    output act_e              act_o,
    output logic              latch_o
);
    logic nonpwm;
    assign nonpwm  = !is_pwm(wave_i);
    // The code in use is reloaded on a match, or on a force in non-PWM modes
    assign latch_o = match_i || (force_i && nonpwm);

    // Decode the action from mode, code and events
    always_comb begin
        act_o = ACT_HOLD;
        unique case (wave_i)
            WM_NORMAL, WM_CTC: begin
                if (match_i || force_i) act_o = act_e'(com_new_i);
            end
            WM_FAST: begin
                if (match_i) begin
                    if (com_new_i == 2'b10)      act_o = ACT_CLEAR;
                    else if (com_new_i == 2'b11) act_o = ACT_SET;
                end else if (bottom_i) begin
                    if (com_act_i == 2'b10)      act_o = ACT_SET;
                    else if (com_act_i == 2'b11) act_o = ACT_CLEAR;
                end
            end
            WM_PHASE: begin
                if (match_i) begin
                    if (com_new_i == 2'b10)      act_o = up_i ? ACT_CLEAR : ACT_SET;
                    else if (com_new_i == 2'b11) act_o = up_i ? ACT_SET : ACT_CLEAR;
                end
            end
            default: act_o = ACT_HOLD;
        endcase
    end
endmodule

// File: rtl/tcmp_oc_reg.sv
// Module: the output-compare flip-flop.
// Applies one decoded action per clock. Resets to 0.
module tcmp_oc_reg
    import tcmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  act_e act_i,
    output logic oc_q
);
    // Apply hold / toggle / clear / set
    always_ff @(posedge clk) begin
        if (!rst_n) oc_q <= 1'b0;
        else begin
            unique case (act_i)
                ACT_TOGGLE: oc_q <= !oc_q;
                ACT_CLEAR:  oc_q <= 1'b0;
                ACT_SET:    oc_q <= 1'b1;
                default:    oc_q <= oc_q;
            endcase
        end
    end
endmodule

// File: rtl/tcmp_pin_mux.sv
// Module: port pin override mux.
// A nonzero compare code selects the flip-flop as pin data. The direction
// bit alone drives the output enable. Independent of waveform mode.
module tcmp_pin_mux #(
    parameter int W = tcmp_pkg::CODE_W
) (
    input  logic [W-1:0] com_i,
    input  logic         oc_i,
    input  logic         port_data_i,
    input  logic         port_dir_i,
    output logic         pin_out_o,
    output logic         pin_oe_o
);
    logic ovr;
    // Override is active for any nonzero code
    assign ovr       = |com_i;
    assign pin_out_o = ovr ? oc_i : port_data_i;
    assign pin_oe_o  = port_dir_i;
endmodule

// File: rtl/tcmp_pin_unit.sv
// Module: timer compare output pin unit (top).
// Ties together the code latch, the action select, the flip-flop and the pin
// mux. Assumes counter events come from an external counter in the same clock.
module tcmp_pin_unit
    import tcmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] wave_mode_i,
    input  logic [1:0] com_i,
    input  logic       match_i,
    input  logic       bottom_i,
    input  logic       count_up_i,
    input  logic       force_i,
    input  logic       port_data_i,
    input  logic       port_dir_i,
    output logic       pin_out_o,
    output logic       pin_oe_o
);
    logic [CODE_W-1:0] com_act;
    logic              latch;
    act_e              act;
    logic              oc_q;

    tcmp_code_latch #(.W(CODE_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .load_i(latch), .code_i(com_i), .code_q(com_act)
    );

    tcmp_action_sel u_sel (
        .wave_i(wave_e'(wave_mode_i)), .com_new_i(com_i), .com_act_i(com_act),
        .match_i(match_i), .bottom_i(bottom_i), .up_i(count_up_i),
        .force_i(force_i), .act_o(act), .latch_o(latch)
    );

    tcmp_oc_reg u_oc (
        .clk(clk), .rst_n(rst_n), .act_i(act), .oc_q(oc_q)
    );

    tcmp_pin_mux #(.W(CODE_W)) u_mux (
        .com_i(com_i), .oc_i(oc_q), .port_data_i(port_data_i),
        .port_dir_i(port_dir_i), .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o)
    );
endmodule

// File: rtl/tcmp_pin_unit_chk.sv
// Checker: temporal properties of the compare flip-flop, bound into the top.
module tcmp_pin_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] wave_i,
    input logic [1:0] com_i,
    input logic       match_i,
    input logic       force_i,
    input logic       oc_q
);
    // R4: a match with code 00 keeps the flip-flop
    a_r4_zero_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && com_i == 2'b00) |=> $stable(oc_q));
    // R5: non-PWM set on match
    a_r5_match_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!wave_i[1] && match_i && com_i == 2'b11) |=> oc_q);
    // R5: non-PWM clear on match
    a_r5_match_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!wave_i[1] && match_i && com_i == 2'b10) |=> !oc_q);
    // R5, R6: non-PWM toggle on match or force
    a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (!wave_i[1] && (match_i || force_i) && com_i == 2'b01) |=> (oc_q != $past(oc_q)));
    // R7: force alone does nothing in PWM modes (no match; BOTTOM excluded in fast PWM)
    a_r7_force_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_i == 2'b11 && force_i && !match_i) |=> $stable(oc_q));
    // R8: fast PWM code 10 clears on match
    a_r8_fast_match_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_i == 2'b10 && match_i && com_i == 2'b10) |=> !oc_q);
endmodule

bind tcmp_pin_unit tcmp_pin_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wave_i(wave_mode_i), .com_i(com_i),
    .match_i(match_i), .force_i(force_i), .oc_q(oc_q)
);

// File: tb/tcmp_pin_unit_tb.sv
module tcmp_pin_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] wave = 2'b00;
    logic [1:0] com = 2'b00;
    logic       match = 1'b0, bottom = 1'b0, up = 1'b1, force_s = 1'b0;
    logic       pdata = 1'b0, pdir = 1'b0;
    logic       pin_out, pin_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference state
    logic       ref_ff = 1'b0;
    logic [1:0] ref_act = 2'b00;

    always #4 clk = !clk;  // 125 MHz

    tcmp_pin_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wave_mode_i(wave), .com_i(com),
        .match_i(match), .bottom_i(bottom), .count_up_i(up), .force_i(force_s),
        .port_data_i(pdata), .port_dir_i(pdir), .pin_out_o(pin_out), .pin_oe_o(pin_oe)
    );

    // Reference: next flip-flop value from the requirements
    function automatic logic ref_next(logic ff, logic [1:0] act, logic [1:0] w,
                                      logic [1:0] c, logic m, logic b, logic u, logic f);
        logic r = ff;
        if (w[1] == 1'b0) begin                    // R5, R6
            if (m || f) begin
                case (c)
                    2'b01: r = !ff;
                    2'b10: r = 1'b0;
                    2'b11: r = 1'b1;
                    default: r = ff;
                endcase
            end
        end else if (w == 2'b10) begin             // R8, R11
            if (m) begin
                if (c == 2'b10) r = 1'b0;
                else if (c == 2'b11) r = 1'b1;
            end else if (b) begin
                if (act == 2'b10) r = 1'b1;
                else if (act == 2'b11) r = 1'b0;
            end
        end else begin                             // R9
            if (m) begin
                if (c == 2'b10) r = u ? 1'b0 : 1'b1;
                else if (c == 2'b11) r = u ? 1'b1 : 1'b0;
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic act_v, input logic exp_v, input string what);
        n_tests++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act_v, exp_v, $time);
        end
    endtask

    // One cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input string req, input logic [1:0] w, input logic [1:0] c,
                        input logic m, input logic b, input logic u, input logic f,
                        input logic d, input logic dir);
        wave = w; com = c; match = m; bottom = b; up = u; force_s = f; pdata = d; pdir = dir;
        @(posedge clk);
        if (rst_n) begin
            ref_ff = ref_next(ref_ff, ref_act, w, c, m, b, u, f);
            if (m || (f && !w[1])) ref_act = c;
        end else begin
            ref_ff = 1'b0; ref_act = 2'b00;
        end
        @(negedge clk);
        check(req, pin_out, (c != 2'b00) ? ref_ff : d, "pin_out");
        check((req == "R2") ? "R2" : req, pin_oe, dir, "pin_oe");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hang expected finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        // R3: reset state
        repeat (3) step("R3", 2'b00, 2'b00, 0, 0, 1, 0, 1, 1);
        rst_n = 1'b1;
        step("R3", 2'b00, 2'b11, 0, 0, 1, 0, 0, 1);
        check("R3", pin_out, 1'b0, "flip-flop after reset");
        // R5: toggle, toggle, clear, set, clear
        step("R5", 2'b00, 2'b01, 1, 0, 1, 0, 0, 1);
        check("R5", pin_out, 1'b1, "toggle to 1");
        step("R5", 2'b00, 2'b01, 1, 0, 1, 0, 0, 1);
        check("R5", pin_out, 1'b0, "toggle to 0");
        step("R5", 2'b01, 2'b11, 1, 0, 1, 0, 0, 1);
        check("R5", pin_out, 1'b1, "set on match CTC");
        step("R5", 2'b01, 2'b10, 1, 0, 1, 0, 0, 1);
        check("R5", pin_out, 1'b0, "clear on match CTC");
        // R6: force sets without match
        step("R6", 2'b01, 2'b11, 0, 0, 1, 1, 0, 1);
        check("R6", pin_out, 1'b1, "force set");
        // R4: code 00 match in every mode keeps 1; pin shows port data
        for (int w = 0; w < 4; w++) step("R4", 2'(w), 2'b00, 1, 0, 1, 0, 0, 1);
        step("R4", 2'b00, 2'b11, 0, 0, 1, 0, 0, 1);
        check("R4", pin_out, 1'b1, "flip-flop kept by code 00 matches");
        // R1: port data shown with code 00 in PWM mode
        step("R1", 2'b10, 2'b00, 0, 0, 1, 0, 0, 1);
        step("R1", 2'b10, 2'b00, 0, 0, 1, 0, 1, 1);
        check("R1", pin_out, 1'b1, "port data through");
        // R7: force in phase PWM ignored
        step("R7", 2'b11, 2'b10, 0, 0, 1, 1, 0, 1);
        check("R7", pin_out, 1'b1, "force ignored in PWM");
        // R8: fast PWM code 10 match clears, bottom sets, coincident -> match
        step("R8", 2'b10, 2'b10, 1, 0, 1, 0, 0, 1);
        check("R8", pin_out, 1'b0, "fast clear on match");
        step("R8", 2'b10, 2'b10, 0, 1, 1, 0, 0, 1);
        check("R8", pin_out, 1'b1, "fast set at bottom");
        step("R8", 2'b10, 2'b10, 1, 1, 1, 0, 0, 1);
        check("R8", pin_out, 1'b0, "match wins over bottom");
        // R11: write 11 without match; bottom still uses 10 -> set
        step("R11", 2'b10, 2'b11, 0, 1, 1, 0, 0, 1);
        check("R11", pin_out, 1'b1, "bottom uses old code");
        step("R11", 2'b10, 2'b11, 1, 0, 1, 0, 0, 1);
        check("R11", pin_out, 1'b1, "match uses new code (set)");
        step("R11", 2'b10, 2'b11, 0, 1, 1, 0, 0, 1);
        check("R11", pin_out, 1'b0, "bottom now uses new code");
        // R9: phase-correct
        step("R9", 2'b11, 2'b10, 1, 0, 0, 0, 0, 1);
        check("R9", pin_out, 1'b1, "down match sets (10)");
        step("R9", 2'b11, 2'b10, 1, 0, 1, 0, 0, 1);
        check("R9", pin_out, 1'b0, "up match clears (10)");
        step("R9", 2'b11, 2'b11, 0, 1, 1, 0, 0, 1);
        check("R9", pin_out, 1'b0, "bottom ignored");
        step("R9", 2'b11, 2'b11, 1, 0, 1, 0, 0, 1);
        check("R9", pin_out, 1'b1, "up match sets (11)");
        // R10: code 01 in PWM idles
        step("R10", 2'b11, 2'b01, 1, 0, 0, 0, 0, 1);
        check("R10", pin_out, 1'b1, "phase code 01 idle");
        step("R10", 2'b10, 2'b01, 1, 1, 1, 0, 0, 1);
        check("R10", pin_out, 1'b1, "fast code 01 idle");
        // R12: preset via force with pin as input, then enable
        step("R12", 2'b00, 2'b10, 0, 0, 1, 1, 1, 0);
        check("R12", pin_oe, 1'b0, "pin still input");
        step("R12", 2'b00, 2'b10, 0, 0, 1, 0, 1, 1);
        check("R12", pin_oe, 1'b1, "pin enabled");
        check("R12", pin_out, 1'b0, "preset level on pin");
        // R2: direction low with override active
        step("R2", 2'b01, 2'b11, 0, 0, 1, 0, 0, 0);
        check("R2", pin_oe, 1'b0, "oe follows dir");
        // R3: mid-run reset
        step("R3", 2'b01, 2'b11, 1, 0, 1, 0, 0, 1);
        rst_n = 1'b0;
        step("R3", 2'b01, 2'b11, 0, 0, 1, 0, 0, 1);
        rst_n = 1'b1;
        step("R3", 2'b01, 2'b11, 0, 0, 1, 0, 0, 1);
        check("R3", pin_out, 1'b0, "cleared by reset");
        // Random phase: R1 R5 R8 R9 R11 under mixed stimulus
        begin
            logic [1:0] rw = 2'b10;
            logic [1:0] rc = 2'b10;
            for (int i = 0; i < 3000; i++) begin
                if ($urandom_range(0, 15) == 0) rw = 2'($urandom_range(0, 3));
                if ($urandom_range(0, 7) == 0)  rc = 2'($urandom_range(0, 3));
                step("R11", rw, rc,
                     ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0),
                     1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0),
                     1'($urandom_range(0, 1)), ($urandom_range(0, 5) != 0));
            end
        end
        finish_run();
    end
endmodule